// File: doc/BRIEF.md
# Deadline-Aware Memory Request Arbiter

This block sits in front of a DRAM controller and picks, in every clock cycle, at most one memory request from four requester ports: a graphics engine, a host processor port, an I/O downstream port and an I/O upstream bus-master port. Each port uses a valid/ready handshake that carries an address and a read/write flag. The I/O downstream port also carries an isochronous flag. Without promotion, the ports are served in a fixed order. Two rules can move the I/O ports to the front. An isochronous downstream request always moves to the front. An upstream request moves to the front once its waiting time passes three quarters of a latency bound. The bound is given in clock cycles as a parameter, and is the cycle count that matches the required wall-clock limit at the clock frequency in use.

Each accepted request goes through a two-stage write pipeline. In the cycle after the grant, the block checks the request's row against the row it tracks as open in the target bank. If they differ, it writes a paging command into the command queue. In the cycle after that, it writes the data entry into the data queue. The queues themselves are outside the block. They report their free slots, and the block counts its own writes still in flight against those counts before it grants. Because the two queues are separate, paging commands for later requests can go out while data entries for earlier requests are still being written.

Addresses are laid out as {row, bank, column}: the column takes the low COL_W bits, the bank the next BANK_W bits, and the row the top ROW_W bits.

Top module: `mem_req_arbiter`

## Requirements
- R1: While rst_n is low, no req_ready bit is set and neither queue write strobe is set. After reset every bank counts as closed, so the first access to any bank produces a command write.
- R2: With no promotion active, the grant goes to the lowest-indexed valid port: 0 graphics, 1 host, 2 I/O downstream, 3 I/O upstream. At most one req_ready bit is set in a cycle, and only for a port whose req_valid is set.
- R3: When port 2 is valid with dn_iso high, port 2 is granted ahead of ports 0 and 1.
- R4: Port 3 keeps a wait count. The count is 0 in the first cycle of a request and rises by one in each further cycle the request stays valid without a grant. Once the count reaches THRESH = (3*DEADLINE)/4, port 3 is granted ahead of ports 0, 1 and a non-isochronous port 2.
- R5: When an isochronous port-2 request and a promoted port-3 request are both present, port 2 wins. Port 3 keeps its promotion into the next cycle.
- R6: The port-3 wait count clears when port 3 is granted, and it stays at zero in any cycle where req_valid[3] is low.
- R7: A grant is given only if cmdq_space is greater than the number of command writes in flight (0 or 1) and dataq_space is greater than the number of data writes in flight (0 to 2). A write counts as in flight from its grant until the cycle in which its strobe is set.
- R8: In the cycle after a grant, cmdq_wr is set if the request's row differs from the open row of its bank, or if that bank is closed. cmdq_bank, cmdq_row and cmdq_src (the port index) describe the request, and that row becomes the bank's open row.
- R9: A request whose row matches the open row of its bank produces no command write.
- R10: Two cycles after a grant, dataq_wr is set with the request's address, read/write flag and port index. Any command write for the same request comes exactly one cycle earlier.
- R11: When no isochronous request is present and queue space is available, an upstream request is granted within DEADLINE cycles of being raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 4 | Request valid, one bit per port |
| req_ready | output | 4 | Grant/accept, one bit per port |
| req_addr | input | 4*ADDR_W | Port i address at bits [i*ADDR_W +: ADDR_W] |
| req_we | input | 4 | Write flag per port (1 = write) |
| dn_iso | input | 1 | Isochronous flag for the port-2 request |
| cmdq_space | input | SPACE_W | Free command queue slots |
| dataq_space | input | SPACE_W | Free data queue slots |
| cmdq_wr | output | 1 | Command queue write strobe |
| cmdq_bank | output | BANK_W | Bank of the paging command |
| cmdq_row | output | ROW_W | Row to open |
| cmdq_src | output | 2 | Port index of the command |
| dataq_wr | output | 1 | Data queue write strobe |
| dataq_addr | output | ADDR_W | Address of the data entry |
| dataq_we | output | 1 | Read/write flag of the data entry |
| dataq_src | output | 2 | Port index of the data entry |

## Verification
The hardest state to reach from the ports is the one where an isochronous downstream request arrives in exactly the cycle in which a starved upstream request has just crossed its promotion threshold. The stimulus keeps the graphics port valid in every cycle so that it absorbs all grants. It holds the upstream request for exactly THRESH cycles, then raises the isochronous request in the crossing cycle. The bench also measures, to the exact cycle, when the wait count is restarted by a grant and when it is restarted by a single idle cycle. Finally, it limits queue space to one slot so that the grant is held off by writes that are in flight but not yet written.

// File: rtl/arb_pkg.sv
package arb_pkg;

    localparam int NREQ  = 4;
    localparam int SRC_W = 2;

    // port indices, also the default priority order (lowest first)
    typedef enum logic [SRC_W-1:0] {
        SRC_GFX  = 2'd0,
        SRC_HOST = 2'd1,
        SRC_IODN = 2'd2,
        SRC_IOUP = 2'd3
    } src_e;

endpackage

// File: rtl/up_wait_timer.sv
module up_wait_timer #(
    parameter int DEADLINE = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pend,
    input  logic granted,
    output logic promote
);
    localparam int CNT_W  = $clog2(DEADLINE + 1);
    localparam int THRESH = (DEADLINE * 3) / 4;

    typedef struct packed {
        logic [CNT_W-1:0] wait_cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!pend || granted) begin
            tmr_d.wait_cnt = '0;
        end else if (tmr_q.wait_cnt != CNT_W'(DEADLINE)) begin
            tmr_d.wait_cnt = tmr_q.wait_cnt + 1'b1;
        end
    end

    assign promote = pend && (tmr_q.wait_cnt >= CNT_W'(THRESH));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // R6
    idle_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pend |=> tmr_q.wait_cnt == '0);

    // R6
    grant_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        granted |=> !promote);

endmodule

// File: rtl/grant_picker.sv
module grant_picker
    import arb_pkg::*;
(
    input  logic            en,
    input  logic [NREQ-1:0] valid,
    input  logic            iso_dn,
    input  logic            promote_up,
    output logic [NREQ-1:0] grant
);
    always_comb begin
        grant = '0;
        if (en) begin
            if (valid[SRC_IODN] && iso_dn) begin
                grant[SRC_IODN] = 1'b1;
            end else if (valid[SRC_IOUP] && promote_up) begin
                grant[SRC_IOUP] = 1'b1;
            end else begin
                for (int i = NREQ - 1; i >= 0; i--) begin
                    if (valid[i]) grant = NREQ'(1) << i;
                end
            end
        end
    end

endmodule

// File: rtl/open_row_table.sv
module open_row_table #(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lookup,
    input  logic [BANK_W-1:0] bank,
    input  logic [ROW_W-1:0]  row,
    output logic              miss
);
    localparam int NBANK = 1 << BANK_W;

    typedef struct packed {
        logic [NBANK-1:0]            open;
        logic [NBANK-1:0][ROW_W-1:0] rows;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        miss  = lookup && (!tbl_q.open[bank] || (tbl_q.rows[bank] != row));
        tbl_d = tbl_q;
        if (miss) begin
            tbl_d.open[bank] = 1'b1;
            tbl_d.rows[bank] = row;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    // R9
    repeat_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup && miss) |=> !(lookup && miss && bank == $past(bank) && row == $past(row)));

endmodule

// File: rtl/mem_req_arbiter.sv
module mem_req_arbiter
    import arb_pkg::*;
#(
    parameter int COL_W    = 8,
    parameter int BANK_W   = 2,
    parameter int ROW_W    = 12,
    parameter int DEADLINE = 64,
    parameter int SPACE_W  = 4,
    localparam int ADDR_W  = ROW_W + BANK_W + COL_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NREQ-1:0]        req_valid,
    output logic [NREQ-1:0]        req_ready,
    input  logic [NREQ*ADDR_W-1:0] req_addr,
    input  logic [NREQ-1:0]        req_we,
    input  logic                   dn_iso,
    input  logic [SPACE_W-1:0]     cmdq_space,
    input  logic [SPACE_W-1:0]     dataq_space,
    output logic                   cmdq_wr,
    output logic [BANK_W-1:0]      cmdq_bank,
    output logic [ROW_W-1:0]       cmdq_row,
    output logic [SRC_W-1:0]       cmdq_src,
    output logic                   dataq_wr,
    output logic [ADDR_W-1:0]      dataq_addr,
    output logic                   dataq_we,
    output logic [SRC_W-1:0]       dataq_src
);
    typedef struct packed {
        logic              vld;
        logic [SRC_W-1:0]  src;
        logic [ADDR_W-1:0] addr;
        logic              we;
    } stage_t;

    typedef struct packed {
        stage_t s1;   // command stage
        stage_t s2;   // data stage
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [ADDR_W-1:0] addr_a [NREQ];
    logic [NREQ-1:0]   grant;
    logic [SRC_W-1:0]  gidx;
    logic              promote_up;
    logic              space_ok;
    logic [1:0]        cmd_inflight;
    logic [1:0]        data_inflight;
    logic              row_miss;

    for (genvar g = 0; g < NREQ; g++) begin : g_addr
        assign addr_a[g] = req_addr[g*ADDR_W +: ADDR_W];
    end

    assign cmd_inflight  = {1'b0, pipe_q.s1.vld};
    assign data_inflight = {1'b0, pipe_q.s1.vld} + {1'b0, pipe_q.s2.vld};
    assign space_ok = (cmdq_space  > SPACE_W'(cmd_inflight)) &&
                      (dataq_space > SPACE_W'(data_inflight));

    up_wait_timer #(.DEADLINE(DEADLINE)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend    (req_valid[SRC_IOUP]),
        .granted (grant[SRC_IOUP]),
        .promote (promote_up)
    );

    grant_picker u_pick (
        .en         (space_ok && rst_n),
        .valid      (req_valid),
        .iso_dn     (dn_iso),
        .promote_up (promote_up),
        .grant      (grant)
    );

    open_row_table #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_rows (
        .clk    (clk),
        .rst_n  (rst_n),
        .lookup (pipe_q.s1.vld),
        .bank   (pipe_q.s1.addr[COL_W +: BANK_W]),
        .row    (pipe_q.s1.addr[COL_W+BANK_W +: ROW_W]),
        .miss   (row_miss)
    );

    always_comb begin
        gidx = '0;
        for (int i = 0; i < NREQ; i++) begin
            if (grant[i]) gidx = SRC_W'(i);
        end
    end

    always_comb begin
        pipe_d         = pipe_q;
        pipe_d.s2      = pipe_q.s1;
        pipe_d.s1.vld  = |grant;
        pipe_d.s1.src  = gidx;
        pipe_d.s1.addr = addr_a[gidx];
        pipe_d.s1.we   = req_we[gidx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign req_ready  = grant;
    assign cmdq_wr    = row_miss;
    assign cmdq_bank  = pipe_q.s1.addr[COL_W +: BANK_W];
    assign cmdq_row   = pipe_q.s1.addr[COL_W+BANK_W +: ROW_W];
    assign cmdq_src   = pipe_q.s1.src;
    assign dataq_wr   = pipe_q.s2.vld;
    assign dataq_addr = pipe_q.s2.addr;
    assign dataq_we   = pipe_q.s2.we;
    assign dataq_src  = pipe_q.s2.src;

    // R2
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready) && ((req_ready & ~req_valid) == '0));

    // R3 R5
    iso_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid[SRC_IODN] && dn_iso && space_ok) |-> req_ready[SRC_IODN]);

    // R4
    promoted_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (promote_up && space_ok && !(req_valid[SRC_IODN] && dn_iso)) |-> req_ready[SRC_IOUP]);

    // R5
    promote_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (promote_up && req_ready[SRC_IODN] && req_valid[SRC_IOUP]) |=> promote_up || !req_valid[SRC_IOUP]);

    // R7
    no_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmdq_space == '0 || dataq_space == '0) |-> req_ready == '0);

    // R10
    cmd_before_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmdq_wr |=> dataq_wr && dataq_src == $past(cmdq_src));

endmodule

// File: tb/tb_mem_req_arbiter.sv
module tb_mem_req_arbiter;

    localparam int CLK_PERIOD = 10;
    localparam int COL_W    = 8;
    localparam int BANK_W   = 2;
    localparam int ROW_W    = 12;
    localparam int DEADLINE = 64;
    localparam int SPACE_W  = 4;
    localparam int ADDR_W   = ROW_W + BANK_W + COL_W;
    localparam int THRESH   = (DEADLINE * 3) / 4;
    localparam int NB       = 1 << BANK_W;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [3:0]          req_valid = '0;
    logic [3:0]          req_ready;
    logic [4*ADDR_W-1:0] req_addr = '0;
    logic [3:0]          req_we = '0;
    logic                dn_iso = 1'b0;
    logic [SPACE_W-1:0]  cmdq_space = '1;
    logic [SPACE_W-1:0]  dataq_space = '1;
    logic                cmdq_wr;
    logic [BANK_W-1:0]   cmdq_bank;
    logic [ROW_W-1:0]    cmdq_row;
    logic [1:0]          cmdq_src;
    logic                dataq_wr;
    logic [ADDR_W-1:0]   dataq_addr;
    logic                dataq_we;
    logic [1:0]          dataq_src;

    int n_chk  = 0;
    int n_fail = 0;

    mem_req_arbiter #(
        .COL_W(COL_W), .BANK_W(BANK_W), .ROW_W(ROW_W),
        .DEADLINE(DEADLINE), .SPACE_W(SPACE_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_we(req_we), .dn_iso(dn_iso),
        .cmdq_space(cmdq_space), .dataq_space(dataq_space),
        .cmdq_wr(cmdq_wr), .cmdq_bank(cmdq_bank), .cmdq_row(cmdq_row), .cmdq_src(cmdq_src),
        .dataq_wr(dataq_wr), .dataq_addr(dataq_addr), .dataq_we(dataq_we), .dataq_src(dataq_src)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [ADDR_W-1:0] mk(input int row, input int bank, input int col);
        return {ROW_W'(row), BANK_W'(bank), COL_W'(col)};
    endfunction

    // ---------------- scoreboard: expected queue writes ----------------
    logic [ROW_W-1:0]  m_row [NB];
    logic [NB-1:0]     m_open;
    logic              e1_v, e1_miss, e2_v;
    logic [ADDR_W-1:0] e1_a, e2_a;
    logic [1:0]        e1_s, e2_s;
    logic              e1_w, e2_w;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_open = '0; e1_v = 0; e2_v = 0; e1_miss = 0;
            e1_a = '0; e2_a = '0; e1_s = '0; e2_s = '0; e1_w = 0; e2_w = 0;
        end else begin
            e2_v = e1_v; e2_a = e1_a; e2_s = e1_s; e2_w = e1_w;
            e1_v = 1'b0; e1_miss = 1'b0;
            for (int i = 0; i < 4; i++) begin
                if (req_valid[i] && req_ready[i]) begin
                    logic [ADDR_W-1:0] a;
                    int b;
                    a = req_addr[i*ADDR_W +: ADDR_W];
                    b = int'(a[COL_W +: BANK_W]);
                    e1_v = 1'b1; e1_a = a; e1_s = 2'(i); e1_w = req_we[i];
                    e1_miss = !m_open[b] || (m_row[b] != a[COL_W+BANK_W +: ROW_W]);
                    m_open[b] = 1'b1;
                    m_row[b]  = a[COL_W+BANK_W +: ROW_W];
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (cmdq_wr || (e1_v && e1_miss)) begin
                // R8 R9: command only on row miss, with bank/row/source
                check(cmdq_wr == (e1_v && e1_miss) &&
                      cmdq_bank == e1_a[COL_W +: BANK_W] &&
                      cmdq_row  == e1_a[COL_W+BANK_W +: ROW_W] && cmdq_src == e1_s,
                      "R8/R9 cmd", {cmdq_wr, cmdq_src, cmdq_bank, cmdq_row},
                      {e1_v && e1_miss, e1_s, e1_a[COL_W +: BANK_W], e1_a[COL_W+BANK_W +: ROW_W]});
            end
            if (dataq_wr || e2_v) begin
                // R10: data entry two cycles after grant
                check(dataq_wr == e2_v && dataq_addr == e2_a && dataq_we == e2_w && dataq_src == e2_s,
                      "R10 data", {dataq_wr, dataq_src, dataq_we, dataq_addr},
                      {e2_v, e2_s, e2_w, e2_a});
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic set_addr(input int p, input logic [ADDR_W-1:0] a);
        req_addr[p*ADDR_W +: ADDR_W] = a;
    endtask

    task automatic go_idle(input int cycles);
        @(negedge clk);
        req_valid = '0; dn_iso = 0; cmdq_space = '1; dataq_space = '1;
        repeat (cycles) @(negedge clk);
    endtask

    // returns cycle index (0-based) at which port 3 is granted; caller at negedge with request up
    task automatic measure_up(output int n);
        n = -1;
        for (int i = 0; i < DEADLINE + 8; i++) begin
            #2;
            if (req_ready[3]) begin n = i; break; end
            @(negedge clk);
        end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;
        req_valid = 4'b0001;
        set_addr(0, mk(1, 0, 0));
        repeat (3) begin
            @(negedge clk);
            // R1
            check(req_ready == 0 && !cmdq_wr && !dataq_wr, "R1 in reset",
                  {req_ready, cmdq_wr, dataq_wr}, 0);
        end
        req_valid = '0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 0 && !cmdq_wr && !dataq_wr, "R1 after reset",
              {req_ready, cmdq_wr, dataq_wr}, 0);
        // first access after reset must miss (bank closed)
        req_valid = 4'b0001; req_we = 4'b0001;
        set_addr(0, mk(0, 0, 5));
        #2 check(req_ready == 4'b0001, "R1 first grant", req_ready, 1);
        @(negedge clk);
        req_valid = '0;
        check(cmdq_wr == 1'b1, "R1 closed bank misses", cmdq_wr, 1);
        go_idle(3);
    endtask

    task automatic t_default_order;
        for (int p = 0; p < 4; p++) set_addr(p, mk(16 + p, p, p));
        req_we = 4'b1010;
        @(negedge clk);
        req_valid = 4'b1111;
        for (int k = 0; k < 4; k++) begin
            #2 check(req_ready == (4'b0001 << k), "R2 order", req_ready, 4'b0001 << k);
            @(negedge clk);
            req_valid[k] = 1'b0;
        end
        #2 check(req_ready == 0, "R2 no valid", req_ready, 0);
        // only the upper two ports
        @(negedge clk);
        req_valid = 4'b1100;
        #2 check(req_ready == 4'b0100, "R2 dn over up", req_ready, 4'b0100);
        go_idle(3);
    endtask

    task automatic t_iso;
        set_addr(0, mk(40, 1, 0)); set_addr(1, mk(41, 2, 0)); set_addr(2, mk(42, 3, 0));
        @(negedge clk);
        req_valid = 4'b0111; dn_iso = 1'b1;
        #2 check(req_ready == 4'b0100, "R3 iso first", req_ready, 4'b0100);
        @(negedge clk);
        dn_iso = 1'b0;
        #2 check(req_ready == 4'b0001, "R3 no iso default", req_ready, 4'b0001);
        go_idle(3);
    endtask

    task automatic t_deadline;
        int n;
        set_addr(0, mk(50, 0, 0)); set_addr(3, mk(51, 1, 0));
        @(negedge clk);
        req_valid = 4'b1001;
        measure_up(n);
        // R4
        check(n == THRESH, "R4 promote at threshold", n, THRESH);
        // R11
        check(n >= 0 && n <= DEADLINE, "R11 within bound", n, DEADLINE);
        // R6: request stays up after grant, count restarts
        @(negedge clk);
        measure_up(n);
        check(n == THRESH, "R6 restart after grant", n, THRESH);
        // R6: idle cycle clears the count
        @(negedge clk);
        req_valid[3] = 1'b0;
        @(negedge clk);
        req_valid[3] = 1'b1;
        for (int i = 0; i < 30; i++) begin
            #2 if (req_ready[3]) check(0, "R6 early grant", i, 30);
            @(negedge clk);
        end
        req_valid[3] = 1'b0;
        @(negedge clk);
        req_valid[3] = 1'b1;
        measure_up(n);
        check(n == THRESH, "R6 idle clears", n, THRESH);
        go_idle(3);
    endtask

    task automatic t_iso_vs_deadline;
        int early;
        early = 0;
        set_addr(0, mk(60, 2, 0)); set_addr(2, mk(61, 3, 0)); set_addr(3, mk(62, 0, 0));
        @(negedge clk);
        req_valid = 4'b1001;
        for (int i = 0; i < THRESH; i++) begin
            #2 if (req_ready[3]) early++;
            @(negedge clk);
        end
        check(early == 0, "R4 not before threshold", early, 0);
        req_valid[2] = 1'b1; dn_iso = 1'b1;
        #2 check(req_ready == 4'b0100, "R5 iso beats promoted", req_ready, 4'b0100);
        @(negedge clk);
        req_valid[2] = 1'b0; dn_iso = 1'b0;
        #2 check(req_ready == 4'b1000, "R5 promotion kept", req_ready, 4'b1000);
        go_idle(3);
    endtask

    task automatic t_space;
        set_addr(0, mk(70, 1, 0));
        @(negedge clk);
        cmdq_space = '0;
        req_valid = 4'b0001;
        #2 check(req_ready == 0, "R7 cmd queue full", req_ready, 0);
        @(negedge clk);
        cmdq_space = '1; dataq_space = '0;
        #2 check(req_ready == 0, "R7 data queue full", req_ready, 0);
        // one data slot: in-flight entries block the next grants
        @(negedge clk);
        dataq_space = SPACE_W'(1);
        #2 check(req_ready == 4'b0001, "R7 slot free", req_ready, 1);
        @(negedge clk);
        #2 check(req_ready == 0, "R7 data in flight s1", req_ready, 0);
        @(negedge clk);
        #2 check(req_ready == 0, "R7 data in flight s2", req_ready, 0);
        @(negedge clk);
        #2 check(req_ready == 4'b0001, "R7 drained", req_ready, 1);
        @(negedge clk);
        req_valid = '0;
        dataq_space = '1;
        repeat (3) @(negedge clk);
        // one command slot
        cmdq_space = SPACE_W'(1);
        req_valid = 4'b0001;
        #2 check(req_ready == 4'b0001, "R7 cmd slot", req_ready, 1);
        @(negedge clk);
        #2 check(req_ready == 0, "R7 cmd in flight", req_ready, 0);
        @(negedge clk);
        #2 check(req_ready == 4'b0001, "R7 cmd drained", req_ready, 1);
        go_idle(3);
    endtask

    task automatic single(input int p, input logic [ADDR_W-1:0] a, input logic w,
                          input logic exp_cmd, input string tag);
        @(negedge clk);
        set_addr(p, a); req_we[p] = w;
        req_valid = 4'(1 << p);
        #2 check(req_ready[p] == 1'b1, "R2 single grant", req_ready, 4'(1 << p));
        @(negedge clk);
        req_valid = '0;
        check(cmdq_wr == exp_cmd, tag, cmdq_wr, exp_cmd);
        @(negedge clk);
        check(dataq_wr == 1'b1 && dataq_addr == a, "R10 data follows", dataq_addr, a);
    endtask

    task automatic t_rows;
        single(0, mk(12'h7A1, 1, 3), 1'b1, 1'b1, "R8 new row");
        single(1, mk(12'h7A1, 1, 9), 1'b0, 1'b0, "R9 same row hit");
        single(0, mk(12'h7A2, 1, 3), 1'b0, 1'b1, "R8 row change");
        single(3, mk(12'h7A2, 2, 0), 1'b1, 1'b1, "R8 other bank");
        single(2, mk(12'h7A2, 1, 1), 1'b1, 1'b0, "R9 kept row");
        go_idle(3);
    endtask

    initial begin
        t_reset();
        t_default_order();
        t_iso();
        t_deadline();
        t_iso_vs_deadline();
        t_space();
        t_rows();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule